// File: doc/BRIEF.md
# Four-Bit Register-File ALU Datapath

A single-cycle datapath made of an eight-entry, four-bit register file and a four-bit arithmetic/logic unit. Two read addresses pick the A and B operands. Both read ports are combinational, so their values reach the ALU within the same cycle. The ALU result is the only source of write data. A third address picks the destination register. A write-enable input gates the write on the rising clock edge. In use, that input is usually a slow-rate strobe, so that each update can be watched.

Register 0 always reads zero and ignores writes. Choosing it as the destination therefore freezes the datapath. The function code carries an operand-A invert bit, an operand-B invert bit and a two-bit operation select. Constants such as 0, -1 and +1 are built by feeding ALU results back into the register file. Counters and sequences are built the same way.

Top module: `rf_alu_datapath`

## Requirements
- R1: A synchronous active-high reset clears every register, so that both read ports then return 0 for every address.
- R2: The read ports are combinational. `opnd_a` always equals the register named by `sel_a`, and `opnd_b` always equals the register named by `sel_b`.
- R3: Register 0 always reads as 0. A write with `sel_dst` = 0 changes no register.
- R4: On a rising clock edge with `wr_en` high and a nonzero `sel_dst`, the register at `sel_dst` takes the value of `result`. With `wr_en` low, no register changes.
- R5: The function code is `func` = {invA (bit 3), invB (bit 2), op (bits 1:0)}. A' is A or its complement, as invA selects. B' is B or its complement, as invB selects. The op values are: 00 gives A' AND B', 01 gives A' OR B', and 10 gives A' + B' + invB. So 0010 adds, 0110 subtracts and 1100 gives NOR.
- R6: With op 11, the result is 1 when A' is less than B as signed 4-bit values, and 0 otherwise. The invB bit has no effect on this comparison.
- R7: The flags are combinational and valid for every op. `flg_zero` is 1 when `result` is 0. `flg_neg` is `result[3]`. `flg_carry` is the carry out of A' + B' + invB. `flg_ovf` is the signed overflow of that same sum.
- R8: When the destination register is also a source, each write uses the values from before the clock edge. Repeatedly adding 1 to a register therefore steps through 1, 2, 3 and so on, and wraps from 15 back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes occur on its rising edge |
| rst | input | 1 | Synchronous active-high reset; clears every register |
| wr_en | input | 1 | Write enable for the current cycle |
| sel_a | input | 3 | Register address for operand A |
| sel_b | input | 3 | Register address for operand B |
| sel_dst | input | 3 | Destination register address |
| func | input | 4 | ALU function code {invA, invB, op} |
| opnd_a | output | 4 | Value of the register at `sel_a` |
| opnd_b | output | 4 | Value of the register at `sel_b` |
| result | output | 4 | ALU result, which is also the write data |
| flg_zero | output | 1 | Result is zero |
| flg_neg | output | 1 | Most significant bit of the result |
| flg_carry | output | 1 | Carry out of the adder |
| flg_ovf | output | 1 | Signed overflow of the adder |

## Verification
The register contents can only be seen through the read ports. A wrong stored value therefore appears on `opnd_a` or `opnd_b` as soon as its address is selected, which is in the same cycle, before any clock edge. If such a value is used as an operand, it also corrupts `result` and the flags at once, and it corrupts the next register written from that result. Operands can only be loaded through ALU feedback. The bench therefore builds every operand pair with that feedback, sweeps all 16 function codes over all 256 pairs, and compares against an arithmetic model. A missed write, a stray write or a wrong feedback value shows up on the next read of the affected register.

// File: rtl/rf_alu_datapath.sv
module rf_alu_datapath #(
  parameter int DW   = 4,
  parameter int NREG = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] sel_a,
  input  logic [AW-1:0] sel_b,
  input  logic [AW-1:0] sel_dst,
  input  logic [3:0]    func,
  output logic [DW-1:0] opnd_a,
  output logic [DW-1:0] opnd_b,
  output logic [DW-1:0] result,
  output logic          flg_zero,
  output logic          flg_neg,
  output logic          flg_carry,
  output logic          flg_ovf
);

  logic [NREG-1:0][DW-1:0] regs;
  logic [DW-1:0] a_in, b_in;
  logic [DW:0]   sum_w;
  logic          less;

  assign opnd_a = regs[sel_a];
  assign opnd_b = regs[sel_b];

  assign a_in  = func[3] ? ~opnd_a : opnd_a;
  assign b_in  = func[2] ? ~opnd_b : opnd_b;
  assign sum_w = {1'b0, a_in} + {1'b0, b_in} + {{DW{1'b0}}, func[2]};
  assign less  = $signed(a_in) < $signed(opnd_b);

  always_comb begin
    case (func[1:0])
      2'b00:   result = a_in & b_in;
      2'b01:   result = a_in | b_in;
      2'b10:   result = sum_w[DW-1:0];
      default: result = {{(DW-1){1'b0}}, less};
    endcase
  end

  assign flg_zero  = (result == '0);
  assign flg_neg   = result[DW-1];
  assign flg_carry = sum_w[DW];
  assign flg_ovf   = (a_in[DW-1] == b_in[DW-1]) && (sum_w[DW-1] != a_in[DW-1]);

  always_ff @(posedge clk) begin
    if (rst)
      regs <= '0;
    else if (wr_en && sel_dst != '0)
      regs[sel_dst] <= result;
  end

  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> regs == '0);

  assert_no_write_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!wr_en || sel_dst == '0) |=> $stable(regs));

  assert_write_lands_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel_dst != '0) |=> regs[$past(sel_dst)] == $past(result));

  assert_slt_single_bit_R6: assert property (@(posedge clk) disable iff (rst)
    (func[1:0] == 2'b11) |-> result[DW-1:1] == '0);

endmodule

// File: tb/rf_alu_datapath_tb.sv
module rf_alu_datapath_tb;
  logic clk = 0, rst = 1, wr_en = 0;
  logic [2:0] sel_a = 0, sel_b = 0, sel_dst = 0;
  logic [3:0] func = 0;
  logic [3:0] opnd_a, opnd_b, result;
  logic flg_zero, flg_neg, flg_carry, flg_ovf;
  int checks = 0, errors = 0;
  int model [8];
  bit done = 0;

  always #10 clk = ~clk;

  rf_alu_datapath u_dut (.*);

  function automatic int sx(int v);
    return (v >= 8) ? v - 16 : v;
  endfunction

  // returns {ovf, carry, res[3:0]}
  function automatic int alu(int a, int b, int f);
    int ae, be, s, res, c, v;
    ae = f[3] ? (~a & 15) : a;
    be = f[2] ? (~b & 15) : b;
    s  = ae + be + f[2];
    c  = (s >> 4) & 1;
    v  = (ae[3] == be[3] && s[3] != ae[3]) ? 1 : 0;
    case (f & 3)
      0: res = ae & be;
      1: res = ae | be;
      2: res = s & 15;
      default: res = (sx(ae) < sx(b)) ? 1 : 0;
    endcase
    return res | (c << 4) | (v << 5);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic op(int f, int ra, int rb, int rd, bit we);
    int r;
    @(negedge clk);
    func = 4'(f); sel_a = 3'(ra); sel_b = 3'(rb); sel_dst = 3'(rd); wr_en = we;
    r = alu(model[ra], model[rb], f) & 15;
    @(negedge clk);
    wr_en = 0;
    if (we && rd != 0) model[rd] = r;
  endtask

  task automatic load(int rd, int v);
    op(4'b0010, 0, 0, rd, 1);
    for (int i = 0; i < v; i++) op(4'b0010, rd, 1, rd, 1);
  endtask

  task automatic peek(int r, string req);
    sel_a = 3'(r); sel_b = 3'(r); #1;
    chk(req, opnd_a, model[r]);
    chk(req, opnd_b, model[r]);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    for (int i = 0; i < 8; i++) peek(i, "R1");

    op(4'b1011, 0, 0, 1, 1);
    peek(1, "R6");
    op(4'b1010, 0, 0, 6, 1);
    peek(6, "R5");

    op(4'b1010, 0, 0, 0, 1);
    peek(0, "R3");
    op(4'b1010, 0, 0, 7, 0);
    peek(7, "R4");

    load(5, 0);
    for (int k = 1; k <= 17; k++) begin
      op(4'b0010, 5, 1, 5, 1);
      sel_a = 5; #1;
      chk("R8", opnd_a, k % 16);
    end

    for (int a = 0; a < 16; a++) begin
      load(2, a);
      for (int b = 0; b < 16; b++) begin
        load(3, b);
        peek(2, "R2");
        peek(3, "R2");
        for (int f = 0; f < 16; f++) begin
          int e;
          @(negedge clk);
          func = 4'(f); sel_a = 2; sel_b = 3; #1;
          e = alu(a, b, f);
          chk((f & 3) == 3 ? "R6" : "R5", result, e & 15);
          chk("R7", flg_carry, (e >> 4) & 1);
          chk("R7", flg_ovf, (e >> 5) & 1);
          chk("R7", flg_zero, ((e & 15) == 0) ? 1 : 0);
          chk("R7", flg_neg, (e >> 3) & 1);
        end
      end
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule